// File: doc/BRIEF.md
# Script Fetch Start and Single-Step Controller

This block decides when a script engine may fetch its next instruction. A sequencer waits in an idle phase until a trigger arrives, issues a one-cycle fetch request carrying the instruction address, and then waits for the engine to report that the instruction finished. What counts as a trigger depends on the run mode. In manual-start mode or single-step mode, only a write of the self-clearing start bit counts. With neither mode set, loading the instruction pointer also launches a fetch. In single-step mode the engine halts after every instruction and raises a step interrupt. In every mode, a pending interrupt stops the chain of fetches when the current instruction ends.

A small configuration register holds three more controls: an interrupt mask, a pin-driver selection and an ID-routing compatibility flag. The interrupt pin is active low. It is driven either push-pull or open-drain, the open-drain form relying on an external weak pull-up. When a selection or reselection ID is captured, the compatibility flag decides whether it is written to the ID register only or to the first-byte register as well. A power-up reset clears every control. A software reset returns the sequencer and the interrupt state to idle but keeps the compatibility flag.

Top module: `script_fetch_ctl`

## Requirements
- R1: After power-up reset, `fetch_req` is 0, `cfg_rdata` is 4'b0000, and the pin is inactive in open-drain form (`irq_o`=0, `irq_oe`=0).
- R2: A write with `cfg_wdata[0]`=1 (start) while the sequencer is idle raises `fetch_req` for exactly one cycle, starting one cycle later. `fetch_addr` then equals the `ip_addr` value presented with the write.
- R3: In manual-start mode (`manual_mode`=1) or single-step mode, an idle sequencer ignores `ip_load` and issues no fetch until start is written.
- R4: Once started outside single-step mode, a `step_done` pulse received while no interrupt is pending or arriving launches the next fetch one cycle later, without a new start write.
- R5: A `step_done` pulse that arrives while an interrupt is pending, or while `irq_src` pulses in the same cycle, returns the sequencer to idle. The next launch then needs a start write, or an `ip_load` when no mode is set.
- R6: In single-step mode (`step_mode`=1), every `step_done` pulse returns the sequencer to idle and makes a step interrupt pending. A start write resumes execution.
- R7: With neither mode set, an `ip_load` pulse in the idle phase launches a fetch one cycle later.
- R8: `cfg_rdata` is {compat[3], push_pull[2], irq_mask[1], start[0]}. The start bit reads 1 only in the cycle after the write that set it. The other bits read back the value last written.
- R9: While `cfg_rdata[1]` (interrupt mask) is 1, the pin is inactive whatever the interrupt state.
- R10: With `cfg_rdata[2]`=1 the pin is push-pull: `irq_oe`=1 and `irq_o` is the inverse of the active interrupt. With it 0 the pin is open-drain: `irq_o`=0 and `irq_oe` equals the active interrupt.
- R11: An `id_cap` pulse raises `idreg_we` in the same cycle. It also raises `firstbyte_we` only when the compatibility bit `cfg_rdata[3]` is 0.
- R12: `soft_rst` returns the sequencer to idle, clears the pending interrupts, the mask and the push-pull bit, and keeps the compatibility bit. Power-up reset clears the compatibility bit.
- R13: `irq_src` or a step event sets a pending interrupt, and `irq_ack` clears it. When a set and `irq_ack` arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| cfg_rdata | output | 4 | Configuration readback |
| manual_mode | input | 1 | Manual-start mode enable |
| step_mode | input | 1 | Single-step mode enable |
| ip_load | input | 1 | Instruction pointer was loaded |
| ip_addr | input | ADDR_W | Current instruction pointer |
| step_done | input | 1 | Current instruction finished |
| irq_src | input | 1 | Interrupt source pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| id_cap | input | 1 | Selection ID captured |
| fetch_req | output | 1 | Instruction fetch request |
| fetch_addr | output | ADDR_W | Fetch address |
| irq_o | output | 1 | Interrupt pin data, active low |
| irq_oe | output | 1 | Interrupt pin output enable |
| idreg_we | output | 1 | ID register write enable |
| firstbyte_we | output | 1 | First-byte register write enable |

## Verification
A fetch request appears one clock after the edge that samples its trigger: a start write, an `ip_load`, or a `step_done`. The start readback bit follows the same one-cycle rule. The pin follows `irq_src` one clock later, because the pending flag is registered, while it follows mask and driver changes one clock after their write. The ID write enables are combinational and respond in the same cycle as `id_cap`. The bench drives inputs after the falling edge, updates a behavioural reference model on the rising edge, and compares every output at the next falling edge, so each result is sampled in the cycle in which it is due. The ID enables are checked shortly after `id_cap` is driven, before the next edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int CFG_W    = 4;
  localparam int B_START  = 0;
  localparam int B_MASK   = 1;
  localparam int B_PUSH   = 2;
  localparam int B_COMPAT = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_EXEC  = 2'd2
  } seq_st_e;

  // Pin drive: returns {data, enable}; the pin is active low.
  function automatic logic [1:0] pin_drive(input logic active, input logic push);
    if (push) pin_drive = {~active, 1'b1};
    else      pin_drive = {1'b0, active};
  endfunction

  // ID routing: returns {id register enable, first-byte enable}.
  function automatic logic [1:0] id_route(input logic cap, input logic compat);
    id_route = {cap, cap & ~compat};
  endfunction
endpackage

// File: rtl/sfc_cfg_regs.sv
module sfc_cfg_regs
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             start_pulse,
  output logic             irq_mask,
  output logic             push_pull,
  output logic             compat,
  output logic [CFG_W-1:0] cfg_rdata
);
  logic start_rb_q;
  logic mask_q;
  logic push_q;
  logic compat_q;

  assign start_pulse = cfg_we & cfg_wdata[B_START];

  // The compatibility flag lives apart: only power-up reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      compat_q <= 1'b0;
    end else if (!soft_rst && cfg_we) begin
      compat_q <= cfg_wdata[B_COMPAT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_rb_q <= 1'b0;
      mask_q     <= 1'b0;
      push_q     <= 1'b0;
    end else if (soft_rst) begin
      start_rb_q <= 1'b0;
      mask_q     <= 1'b0;
      push_q     <= 1'b0;
    end else begin
      start_rb_q <= start_pulse;
      if (cfg_we) begin
        mask_q <= cfg_wdata[B_MASK];
        push_q <= cfg_wdata[B_PUSH];
      end
    end
  end

  assign irq_mask  = mask_q;
  assign push_pull = push_q;
  assign compat    = compat_q;

  always_comb begin
    cfg_rdata           = '0;
    cfg_rdata[B_START]  = start_rb_q;
    cfg_rdata[B_MASK]   = mask_q;
    cfg_rdata[B_PUSH]   = push_q;
    cfg_rdata[B_COMPAT] = compat_q;
  end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start_pulse,
  input  logic              manual_mode,
  input  logic              step_mode,
  input  logic              ip_load,
  input  logic [ADDR_W-1:0] ip_addr,
  input  logic              step_done,
  input  logic              halt_req,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              step_evt,
  output logic              seq_idle,
  output logic              seq_exec
);
  seq_st_e           st_q, st_nx;
  logic              launch;
  logic              auto_run;
  logic [ADDR_W-1:0] addr_q;

  assign auto_run = ~manual_mode & ~step_mode;

  always_comb begin
    st_nx    = st_q;
    launch   = 1'b0;
    step_evt = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        launch = start_pulse | (auto_run & ip_load);
      end
      SEQ_FETCH: begin
        st_nx = SEQ_EXEC;
      end
      SEQ_EXEC: begin
        if (step_done) begin
          if (step_mode) begin
            step_evt = 1'b1;
            st_nx    = SEQ_IDLE;
          end else if (halt_req) begin
            st_nx = SEQ_IDLE;
          end else begin
            launch = 1'b1;
          end
        end
      end
      default: st_nx = SEQ_IDLE;
    endcase
    if (launch) st_nx = SEQ_FETCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
    end else if (soft_rst) begin
      st_q <= SEQ_IDLE;
    end else begin
      st_q <= st_nx;
      if (launch) addr_q <= ip_addr;
    end
  end

  assign fetch_req  = (st_q == SEQ_FETCH);
  assign fetch_addr = addr_q;
  assign seq_idle   = (st_q == SEQ_IDLE);
  assign seq_exec   = (st_q == SEQ_EXEC);
endmodule

// File: rtl/sfc_irq.sv
module sfc_irq
  import sfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic irq_src,
  input  logic step_evt,
  input  logic irq_ack,
  input  logic irq_mask,
  input  logic push_pull,
  output logic irq_pend,
  output logic halt_req,
  output logic irq_o,
  output logic irq_oe
);
  logic src_q;
  logic stp_q;
  logic active;
  logic [1:0] drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      stp_q <= 1'b0;
    end else if (soft_rst) begin
      src_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      if (irq_src)      src_q <= 1'b1;
      else if (irq_ack) src_q <= 1'b0;
      if (step_evt)     stp_q <= 1'b1;
      else if (irq_ack) stp_q <= 1'b0;
    end
  end

  assign irq_pend = src_q | stp_q;
  assign halt_req = irq_pend | irq_src;
  assign active   = irq_pend & ~irq_mask;
  assign drv      = pin_drive(active, push_pull);
  assign irq_o    = drv[1];
  assign irq_oe   = drv[0];
endmodule

// File: rtl/script_fetch_ctl.sv
module script_fetch_ctl
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic              manual_mode,
  input  logic              step_mode,
  input  logic              ip_load,
  input  logic [ADDR_W-1:0] ip_addr,
  input  logic              step_done,
  input  logic              irq_src,
  input  logic              irq_ack,
  input  logic              id_cap,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              irq_o,
  output logic              irq_oe,
  output logic              idreg_we,
  output logic              firstbyte_we
);
  logic       start_pulse;
  logic       irq_mask;
  logic       push_pull;
  logic       compat;
  logic       halt_req;
  logic       step_evt;
  logic       irq_pend;
  logic       seq_idle;
  logic       seq_exec;
  logic [1:0] id_en;

  sfc_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .start_pulse (start_pulse),
    .irq_mask    (irq_mask),
    .push_pull   (push_pull),
    .compat      (compat),
    .cfg_rdata   (cfg_rdata)
  );

  sfc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .start_pulse (start_pulse),
    .manual_mode (manual_mode),
    .step_mode   (step_mode),
    .ip_load     (ip_load),
    .ip_addr     (ip_addr),
    .step_done   (step_done),
    .halt_req    (halt_req),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .step_evt    (step_evt),
    .seq_idle    (seq_idle),
    .seq_exec    (seq_exec)
  );

  sfc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .irq_src   (irq_src),
    .step_evt  (step_evt),
    .irq_ack   (irq_ack),
    .irq_mask  (irq_mask),
    .push_pull (push_pull),
    .irq_pend  (irq_pend),
    .halt_req  (halt_req),
    .irq_o     (irq_o),
    .irq_oe    (irq_oe)
  );

  assign id_en        = id_route(id_cap, compat);
  assign idreg_we     = id_en[1];
  assign firstbyte_we = id_en[0];
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              manual_mode,
  input logic              step_mode,
  input logic              step_done,
  input logic [ADDR_W-1:0] ip_addr,
  input logic              id_cap,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              irq_o,
  input logic              irq_oe,
  input logic              idreg_we,
  input logic              firstbyte_we,
  input logic [3:0]        cfg_rdata,
  input logic              seq_idle,
  input logic              seq_exec,
  input logic              irq_pend,
  input logic              start_pulse,
  input logic              irq_mask,
  input logic              push_pull,
  input logic              compat
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (seq_idle && start_pulse) |=> (fetch_req && fetch_addr == $past(ip_addr)));

  p_manual_wait_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (seq_idle && manual_mode && !start_pulse) |=> !fetch_req);

  p_fetch_then_exec_r4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    fetch_req |=> (seq_exec && !fetch_req));

  p_step_stop_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (seq_exec && step_done && step_mode) |=> (seq_idle && irq_pend));

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |=> !cfg_rdata[0]);

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> (irq_o == push_pull && irq_oe == push_pull));

  p_od_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull |-> !irq_o);

  p_id_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    id_cap |-> (idreg_we && (firstbyte_we != compat)));

  p_soft_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (compat == $past(compat)));
endmodule

bind script_fetch_ctl sfc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .manual_mode  (manual_mode),
  .step_mode    (step_mode),
  .step_done    (step_done),
  .ip_addr      (ip_addr),
  .id_cap       (id_cap),
  .fetch_req    (fetch_req),
  .fetch_addr   (fetch_addr),
  .irq_o        (irq_o),
  .irq_oe       (irq_oe),
  .idreg_we     (idreg_we),
  .firstbyte_we (firstbyte_we),
  .cfg_rdata    (cfg_rdata),
  .seq_idle     (seq_idle),
  .seq_exec     (seq_exec),
  .irq_pend     (irq_pend),
  .start_pulse  (start_pulse),
  .irq_mask     (irq_mask),
  .push_pull    (push_pull),
  .compat       (compat)
);

// File: tb/script_fetch_ctl_test.sv
module script_fetch_ctl_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_wdata = 4'b0;
  logic [3:0]    cfg_rdata;
  logic          manual_mode = 1'b0;
  logic          step_mode = 1'b0;
  logic          ip_load = 1'b0;
  logic [AW-1:0] ip_addr = '0;
  logic          step_done = 1'b0;
  logic          irq_src = 1'b0;
  logic          irq_ack = 1'b0;
  logic          id_cap = 1'b0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          irq_o, irq_oe, idreg_we, firstbyte_we;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 1'b0;
  string cur = "R1";

  always #10 clk = ~clk;

  script_fetch_ctl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .manual_mode(manual_mode),
    .step_mode(step_mode), .ip_load(ip_load), .ip_addr(ip_addr),
    .step_done(step_done), .irq_src(irq_src), .irq_ack(irq_ack),
    .id_cap(id_cap), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .irq_o(irq_o), .irq_oe(irq_oe), .idreg_we(idreg_we),
    .firstbyte_we(firstbyte_we)
  );

  // Reference model: phase 0 waiting, 1 fetching, 2 executing.
  int      m_phase = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_src = 0, m_stp = 0, m_mask = 0, m_push = 0, m_cmp = 0, m_srb = 0;

  always @(posedge clk) begin
    bit go, start, was_pending, step_hit;
    go = 0; step_hit = 0;
    start = cfg_we && cfg_wdata[0];
    was_pending = m_src || m_stp || irq_src;
    if (!rst_n) begin
      m_phase = 0; m_addr = '0; m_src = 0; m_stp = 0;
      m_mask = 0; m_push = 0; m_cmp = 0; m_srb = 0;
    end else if (soft_rst) begin
      m_phase = 0; m_src = 0; m_stp = 0; m_mask = 0; m_push = 0; m_srb = 0;
    end else begin
      if (m_phase == 0) begin
        go = start || (!manual_mode && !step_mode && ip_load);
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else if (step_done) begin
        if (step_mode) begin m_phase = 0; step_hit = 1; end
        else if (was_pending) m_phase = 0;
        else go = 1;
      end
      if (go) begin m_phase = 1; m_addr = ip_addr; end
      m_srb = start;
      if (cfg_we) begin
        m_mask = cfg_wdata[1]; m_push = cfg_wdata[2]; m_cmp = cfg_wdata[3];
      end
      if (irq_src) m_src = 1; else if (irq_ack) m_src = 0;
      if (step_hit) m_stp = 1; else if (irq_ack) m_stp = 0;
    end
  end

  task automatic check(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    bit act;
    act = (m_src || m_stp) && !m_mask;
    check(cur, "fetch_req", {31'b0, fetch_req}, {31'b0, m_phase == 1});
    if (m_phase == 1) check(cur, "fetch_addr", fetch_addr, m_addr);
    check(cur, "cfg_rdata", {28'b0, cfg_rdata}, {28'b0, m_cmp, m_push, m_mask, m_srb});
    check(cur, "irq_o",  {31'b0, irq_o},  {31'b0, m_push ? !act : 1'b0});
    check(cur, "irq_oe", {31'b0, irq_oe}, {31'b0, m_push ? 1'b1 : act});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    cfg_we = 0; ip_load = 0; step_done = 0; irq_src = 0;
    irq_ack = 0; id_cap = 0; soft_rst = 0;
  endtask

  task automatic wr(logic [3:0] d);
    cfg_we = 1; cfg_wdata = d;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset fetch_req", {31'b0, fetch_req}, 0);
    check("R1", "reset cfg_rdata", {28'b0, cfg_rdata}, 0);
    check("R1", "reset irq_oe", {31'b0, irq_oe}, 0);
    rst_n = 1;
    tick(); tick();

    cur = "R3";
    manual_mode = 1; ip_addr = 32'h100; ip_load = 1; tick(); tick(); tick();

    cur = "R2";
    wr(4'b0001);
    check("R2", "fetch after start", {31'b0, fetch_req}, 1);
    check("R2", "fetch address", fetch_addr, 32'h100);
    tick();

    cur = "R4";
    ip_addr = 32'h104; step_done = 1; tick();
    check("R4", "chained fetch", {31'b0, fetch_req}, 1);
    tick();
    ip_addr = 32'h108; step_done = 1; tick(); tick();

    cur = "R5";
    irq_src = 1; tick();
    step_done = 1; tick();
    check("R5", "halt on pending", {31'b0, fetch_req}, 0);
    tick(); ip_load = 1; tick(); tick();
    irq_ack = 1; tick();
    ip_addr = 32'h200; wr(4'b0001); tick();
    step_done = 1; irq_src = 1; tick(); tick();
    irq_ack = 1; tick();

    cur = "R6";
    manual_mode = 0; step_mode = 1;
    ip_addr = 32'h300; wr(4'b0001); tick();
    step_done = 1; tick();
    check("R6", "step halts", {31'b0, fetch_req}, 0);
    tick(); ip_load = 1; tick(); tick();
    irq_ack = 1; tick();
    ip_addr = 32'h304; wr(4'b0001); tick();
    step_done = 1; tick(); tick();

    cur = "R7";
    step_mode = 0; irq_ack = 1; tick();
    ip_addr = 32'h400; ip_load = 1; tick();
    check("R7", "auto launch", {31'b0, fetch_req}, 1);
    tick(); ip_addr = 32'h404; step_done = 1; tick(); tick();
    irq_src = 1; step_done = 1; tick(); tick();

    cur = "R8";
    wr(4'b0110); tick(); wr(4'b0111); wr(4'b0001); tick();
    check("R8", "start self-clears", {31'b0, cfg_rdata[0]}, 0);

    cur = "R9";
    irq_src = 1; tick();
    wr(4'b0010); tick(); wr(4'b0110); tick();
    cur = "R10";
    wr(4'b0100); tick();
    check("R10", "push-pull low", {31'b0, irq_o}, 0);
    wr(4'b0000); tick();
    check("R10", "open-drain enable", {31'b0, irq_oe}, 1);

    cur = "R11";
    for (int c = 0; c < 2; c++) begin
      wr({c[0], 3'b000});
      id_cap = 1; #1;
      check("R11", "idreg_we", {31'b0, idreg_we}, 1);
      check("R11", "firstbyte_we", {31'b0, firstbyte_we}, {31'b0, c == 0});
      tick();
    end

    cur = "R12";
    wr(4'b1110); irq_src = 1; tick();
    soft_rst = 1; tick();
    check("R12", "soft reset keeps compat", {28'b0, cfg_rdata}, 4'b1000);
    check("R12", "soft reset idle pin", {31'b0, irq_oe}, 0);
    rst_n = 0; tick();
    check("R12", "power reset clears compat", {28'b0, cfg_rdata}, 0);
    rst_n = 1; tick();

    cur = "R13";
    irq_src = 1; irq_ack = 1; tick();
    check("R13", "set wins over ack", {31'b0, irq_oe}, 1);
    irq_ack = 1; tick();
    check("R13", "ack clears", {31'b0, irq_oe}, 0);
    tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule